// File: doc/BRIEF.md
# Power-Management Operating Mode Controller

This block is the mode state machine of a supply and transceiver supervisor. It keeps the chip in one of five operating modes: Off, Standby, Normal, Sleep and Overtemp. Three kinds of event move it between modes. Supply and thermal comparator flags form the first kind. A two-bit mode-select field written by software forms the second. Wake events and system-reset requests form the third.

From the mode it produces the following outputs:
- the enables for the two voltage regulators;
- the state of each bus transceiver;
- the watchdog operating mode;
- a reset pulse whose width is counted in clock cycles.

The current mode is available in two forms: as a one-hot vector and as an encoded status field. The analog comparators, the transceivers and the watchdog counter sit outside this block. They connect to it through these flags and outputs.

Top module: `pm_mode_ctrl`

## Requirements
- R1: After `rst_n` is released the mode is Off (`mode_code` 0). Both regulator enables are 0, both transceiver states are 2'b11 (high impedance) and `rst_pulse` is 0.
- R2: When `bat_poff` is 1 at a clock edge, the mode becomes Off. This holds in every mode and ahead of every other event.
- R3: In Off, `bat_pon` moves the mode to Standby (`mode_code` 1). It also raises `rst_pulse` for exactly RST_W cycles.
- R4: A write (`mc_wr`) in Standby selects a mode from `mc_wdata`. 2'b00 keeps Standby. 2'b01 selects Sleep (`mode_code` 3). 2'b10 and 2'b11 select Normal (`mode_code` 2).
- R5: A write in Normal selects a mode the same way. 2'b00 returns to Standby and 2'b01 selects Sleep. 2'b10 and 2'b11 stay in Normal and set the second regulator off or on.
- R6: In Sleep, `wake` returns the mode to Standby. Register writes in Sleep are ignored.
- R7: Outside Off, `ot_act` forces Overtemp (`mode_code` 4). Overtemp ignores writes. It moves to Standby only when `ot_rel` is 1 and `ot_act` is 0.
- R8: `sys_rst_req` in Standby, Normal or Sleep moves the mode to Standby and restarts `rst_pulse` for RST_W cycles. It ranks below over-temperature and above register writes.
- R9: Each transceiver state is encoded 2'b00 off, 2'b01 low-power with wake detection, 2'b10 active and 2'b11 high impedance. The state depends on the mode:
  - Standby: 2'b01 if its standby bit is 1, else 2'b00.
  - Normal: 2'b01 if its standby bit is 1, else 2'b10.
  - Sleep: 2'b01.
  - Overtemp: 2'b00.
  - Off: 2'b11.
- R10: `wd_timeout` is 1 in Normal when `wd_dis` is 0. It is 1 in Standby or Sleep when `wd_dis` is 0 and `wd_mode_bit` is 1. Otherwise it is 0.
- R11: `mode_oh` has exactly one bit set, at index `mode_code`.
- R12: `reg1_en` is 1 only in Standby and Normal. `reg2_en` is 1 only in Normal entered or updated with code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bat_pon | input | 1 | Battery above power-on threshold |
| bat_poff | input | 1 | Battery below power-off threshold |
| ot_act | input | 1 | Temperature above activation threshold |
| ot_rel | input | 1 | Temperature below release threshold |
| mc_wr | input | 1 | Mode-select write strobe |
| mc_wdata | input | 2 | Mode-select write data |
| wake | input | 1 | Bus or local wake event |
| sys_rst_req | input | 1 | System reset request |
| can_stb | input | 1 | CAN transceiver standby bit |
| lin_stb | input | 1 | LIN transceiver standby bit |
| wd_dis | input | 1 | Watchdog disable pin |
| wd_mode_bit | input | 1 | Watchdog mode-control bit |
| mode_oh | output | 5 | One-hot mode (bit index = mode code) |
| mode_code | output | 3 | Encoded mode: 0 Off, 1 Standby, 2 Normal, 3 Sleep, 4 Overtemp |
| reg1_en | output | 1 | First regulator enable |
| reg2_en | output | 1 | Second regulator enable |
| can_state | output | 2 | CAN transceiver state |
| lin_state | output | 2 | LIN transceiver state |
| wd_timeout | output | 1 | Watchdog in timeout mode |
| rst_pulse | output | 1 | System reset pulse |

## Verification
Mode changes, regulator enables and the start of the reset pulse all come from registers. Each appears one clock after the edge that samples the stimulus.

The transceiver states and the watchdog mode also depend on inputs through combinational paths. They follow the standby bits and watchdog inputs within the same cycle.

The bench drives every input on a falling edge. It checks registered results at the next falling edge, after exactly one rising edge. It measures the pulse width by counting the falling edges at which `rst_pulse` stays high.

// File: rtl/pm_mode_ctrl.sv
module pm_mode_ctrl #(
  parameter int RST_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bat_pon,
  input  logic       bat_poff,
  input  logic       ot_act,
  input  logic       ot_rel,
  input  logic       mc_wr,
  input  logic [1:0] mc_wdata,
  input  logic       wake,
  input  logic       sys_rst_req,
  input  logic       can_stb,
  input  logic       lin_stb,
  input  logic       wd_dis,
  input  logic       wd_mode_bit,
  output logic [4:0] mode_oh,
  output logic [2:0] mode_code,
  output logic       reg1_en,
  output logic       reg2_en,
  output logic [1:0] can_state,
  output logic [1:0] lin_state,
  output logic       wd_timeout,
  output logic       rst_pulse
);
  localparam int CW = $clog2(RST_W + 1);

  typedef enum logic [2:0] {
    M_OFF = 3'd0, M_STBY = 3'd1, M_NORM = 3'd2, M_SLEEP = 3'd3, M_OVT = 3'd4
  } mode_t;

  mode_t mode, nxt;
  logic  v2, nv2, load;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt  = mode;
    nv2  = v2;
    load = 1'b0;
    if (bat_poff) nxt = M_OFF;
    else begin
      case (mode)
        M_OFF: if (bat_pon) begin nxt = M_STBY; load = 1'b1; end
        M_OVT: if (ot_rel && !ot_act) nxt = M_STBY;
        default: begin
          if (ot_act) nxt = M_OVT;
          else if (sys_rst_req) begin nxt = M_STBY; load = 1'b1; end
          else if (mode == M_SLEEP) begin
            if (wake) nxt = M_STBY;
          end else if (mc_wr) begin
            case (mc_wdata)
              2'b00:   nxt = M_STBY;
              2'b01:   nxt = M_SLEEP;
              default: begin nxt = M_NORM; nv2 = mc_wdata[0]; end
            endcase
          end
        end
      endcase
    end
    if (nxt != M_NORM) nv2 = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= M_OFF;
      v2   <= 1'b0;
      cnt  <= '0;
    end else begin
      mode <= nxt;
      v2   <= nv2;
      if (load)          cnt <= CW'(RST_W);
      else if (cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  function automatic logic [1:0] xcvr(input mode_t m, input logic stb);
    case (m)
      M_OFF:   return 2'b11;
      M_STBY:  return stb ? 2'b01 : 2'b00;
      M_NORM:  return stb ? 2'b01 : 2'b10;
      M_SLEEP: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  assign mode_code  = mode;
  assign mode_oh    = 5'd1 << mode;
  assign reg1_en    = (mode == M_STBY) || (mode == M_NORM);
  assign reg2_en    = (mode == M_NORM) && v2;
  assign can_state  = xcvr(mode, can_stb);
  assign lin_state  = xcvr(mode, lin_stb);
  assign rst_pulse  = (cnt != 0);
  assign wd_timeout = !wd_dis && ((mode == M_NORM) ||
                      (((mode == M_STBY) || (mode == M_SLEEP)) && wd_mode_bit));
endmodule

// File: rtl/pm_mode_ctrl_chk.sv
module pm_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bat_pon,
  input logic       bat_poff,
  input logic       ot_act,
  input logic       wake,
  input logic       sys_rst_req,
  input logic [4:0] mode_oh,
  input logic [2:0] mode_code,
  input logic       reg1_en,
  input logic       reg2_en,
  input logic       rst_pulse
);
  p_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_oh == (5'd1 << mode_code));

  p_poff_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bat_poff |=> (mode_code == 3'd0));

  p_pon_stby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd0 && !bat_poff && bat_pon) |=> (mode_code == 3'd1 && rst_pulse));

  p_ot_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code != 3'd0 && !bat_poff && ot_act) |=> (mode_code == 3'd4));

  p_sleep_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_code == 3'd3 && !bat_poff && !ot_act && !wake && !sys_rst_req) |=> (mode_code == 3'd3));

  p_reg_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (reg2_en |-> mode_code == 3'd2) and (reg1_en |-> (mode_code == 3'd1 || mode_code == 3'd2)));
endmodule

bind pm_mode_ctrl pm_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bat_pon(bat_pon), .bat_poff(bat_poff),
  .ot_act(ot_act), .wake(wake), .sys_rst_req(sys_rst_req),
  .mode_oh(mode_oh), .mode_code(mode_code), .reg1_en(reg1_en),
  .reg2_en(reg2_en), .rst_pulse(rst_pulse)
);

// File: tb/pm_mode_ctrl_test.sv
module pm_mode_ctrl_test;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bat_pon = 0, bat_poff = 0, ot_act = 0, ot_rel = 0, mc_wr = 0, wake = 0, sys_rst_req = 0;
  logic [1:0] mc_wdata = 2'b00;
  logic can_stb = 0, lin_stb = 0, wd_dis = 0, wd_mode_bit = 0;
  logic [4:0] mode_oh;
  logic [2:0] mode_code;
  logic reg1_en, reg2_en, wd_timeout, rst_pulse;
  logic [1:0] can_state, lin_state;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pm_mode_ctrl #(.RST_W(W)) uut (.*);

  // [12]poff [11]pon [10]ota [9]otr [8]wr [7:6]wdata [5]wake [4]srr [3:1]exp mode [0]exp reg2
  localparam logic [12:0] VEC [16] = '{
    13'b0_1_0_0_0_00_0_0_001_0,  // Off -> Standby (R3)
    13'b0_0_0_0_0_00_0_0_001_0,  // idle
    13'b0_0_0_0_1_11_0_0_010_1,  // Normal, reg2 on (R4)
    13'b0_0_0_0_1_10_0_0_010_0,  // Normal, reg2 off (R5)
    13'b0_0_0_0_1_01_0_0_011_0,  // Sleep (R5)
    13'b0_0_0_0_1_10_0_0_011_0,  // write ignored (R6)
    13'b0_0_0_0_0_00_1_0_001_0,  // wake -> Standby (R6)
    13'b0_0_0_0_1_10_0_0_010_0,  // Normal (R4)
    13'b0_0_1_0_0_00_0_0_100_0,  // Overtemp (R7)
    13'b0_0_0_0_1_11_0_0_100_0,  // write ignored (R7)
    13'b0_0_0_1_0_00_0_0_001_0,  // release -> Standby (R7)
    13'b0_0_0_0_1_11_0_0_010_1,  // Normal reg2 on
    13'b0_0_0_0_0_00_0_1_001_0,  // reset request -> Standby (R8)
    13'b0_0_0_0_1_11_0_0_010_1,  // Normal
    13'b1_0_0_0_1_00_0_0_000_0,  // poff beats write (R2)
    13'b0_1_0_0_0_00_0_0_001_0   // pon again (R3)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic [8:0] v);
    {bat_poff, bat_pon, ot_act, ot_rel, mc_wr, mc_wdata, wake, sys_rst_req} = v;
    @(negedge clk);
    {bat_poff, bat_pon, ot_act, ot_rel, mc_wr, mc_wdata, wake, sys_rst_req} = '0;
  endtask

  task automatic count_pulse(output int n);
    n = 0;
    while (rst_pulse && n < 40) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", mode_code, 0);
    chk("R1 reg1", reg1_en, 0);
    chk("R1 reg2", reg2_en, 0);
    chk("R1 can", can_state, 3);
    chk("R1 lin", lin_state, 3);
    chk("R1 pulse", rst_pulse, 0);

    for (int i = 0; i < 16; i++) begin
      step(VEC[i][12:4]);
      chk($sformatf("R4/R5/R6/R7/R8 vec%0d mode", i), mode_code, VEC[i][3:1]);
      chk($sformatf("R12 vec%0d reg2", i), reg2_en, VEC[i][0]);
      chk($sformatf("R11 vec%0d onehot", i), mode_oh, 1 << VEC[i][3:1]);
    end

    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
    step(9'b0_1_0_0_0_00_0_0);
    count_pulse(n);
    chk("R3 pulse width", n, W);

    step(9'b0_0_0_0_0_00_0_1);
    @(negedge clk);
    chk("R8 pulse mid", rst_pulse, 1);
    step(9'b0_0_0_0_0_00_0_1);
    count_pulse(n);
    chk("R8 pulse restart", n, W);

    step(9'b0_0_0_0_1_00_0_0);
    chk("R4 write 00 keeps Standby", mode_code, 1);
    chk("R12 reg1 in Standby", reg1_en, 1);
    can_stb = 1; lin_stb = 0; #1;
    chk("R9 Standby can stb1", can_state, 1);
    chk("R9 Standby lin stb0", lin_state, 0);
    wd_dis = 0; wd_mode_bit = 1; #1;
    chk("R10 Standby timeout", wd_timeout, 1);
    wd_mode_bit = 0; #1;
    chk("R10 Standby off", wd_timeout, 0);

    step(9'b0_0_0_0_1_10_0_0);
    chk("R9 Normal can stb1", can_state, 1);
    chk("R9 Normal lin stb0", lin_state, 2);
    chk("R10 Normal timeout", wd_timeout, 1);
    wd_dis = 1; #1;
    chk("R10 Normal pin off", wd_timeout, 0);
    wd_dis = 0;

    step(9'b0_0_0_0_1_01_0_0);
    chk("R9 Sleep lin", lin_state, 1);
    chk("R12 reg1 in Sleep", reg1_en, 0);

    step(9'b1_0_1_0_0_00_0_1);
    chk("R2 poff priority", mode_code, 0);
    chk("R2 Off can hiz", can_state, 3);

    step(9'b0_1_0_0_0_00_0_0);
    step(9'b0_0_1_0_0_00_0_1);
    chk("R8 overtemp beats reset", mode_code, 4);
    chk("R9 Overtemp can", can_state, 0);
    step(9'b0_0_1_1_0_00_0_0);
    chk("R7 release blocked while active", mode_code, 4);
    step(9'b0_0_0_1_0_00_0_0);
    chk("R7 release", mode_code, 1);
    step(9'b0_0_0_0_1_01_0_1);
    chk("R8 reset beats write", mode_code, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule